// File: doc/BRIEF.md
# Dual Converter Start Sequencer

This block turns two trigger pulses, one for a regular conversion group and one for an injected conversion group, into start-of-conversion strobes for a pair of analog-to-digital converter front ends. A 4-bit mode field sets how each group's trigger is spread over the two converters. A group can start only converter 1, start both converters together, interleave the two converters on one channel with fixed cycle gaps, or alternate between them on each new trigger. Converter 2 never sees a trigger of its own; every strobe it gets comes from this sequencer.

Interleaved sequences run from an internal cycle counter. While a sequence is running, further regular triggers are dropped and counted. The mode field is only taken in while no sequence is running. A strobe that would let both converters sample the same channel at once is withheld and reported on an error pulse instead.

Top module: `dual_conv_trigger_seq`

## Requirements
- R1: Mode codes are 0 independent, 1 regular-simultaneous with injected-simultaneous, 2 regular-simultaneous with injected-alternate, 3 injected-simultaneous with regular-fast-interleave, 4 injected-simultaneous with regular-slow-interleave, 5 injected-simultaneous only, 6 regular-simultaneous only, 7 regular-fast-interleave only, 8 regular-slow-interleave only, 9 injected-alternate only. Codes 0 and 10 to 15 act as independent. In independent behaviour a trigger strobes converter 1 of its group only, one cycle after the clock edge that samples the trigger.
- R2: A group set to simultaneous strobes both converters of that group in the same cycle, one cycle after the trigger is sampled.
- R3: In fast interleave (modes 3, 7) a regular trigger strobes converter 1 one cycle after it is sampled and converter 2 exactly 7 cycles after the converter 1 strobe.
- R4: In slow interleave (modes 4, 8) with singleChan high, a regular trigger strobes converter 1, then converter 2 14 cycles later, then converter 1 again 28 cycles after the first strobe.
- R5: In slow interleave with singleChan low, a regular trigger produces no strobe and a one-cycle conflictErr pulse in the cycle where the converter 1 strobe would have appeared.
- R6: In injected-alternate (modes 2, 9) successive injected triggers strobe converter 1, converter 2, converter 1 and so on, never both at once.
- R7: A delayed interleave strobe is withheld, and conflictErr pulses in its place, when the other converter's busy input is high in the cycle before that strobe would appear.
- R8: A regular trigger sampled while an interleave sequence is pending produces no strobe and adds one to overrunCount, which saturates at 255.
- R9: modeSel is taken in only while no interleave sequence is pending, so a running sequence completes under the mode it began with. Taking in a new mode code also resets the alternation so the next injected-alternate trigger goes to converter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 4 | Dual-converter mode code |
| regTrig | input | 1 | Regular group trigger pulse |
| injTrig | input | 1 | Injected group trigger pulse |
| singleChan | input | 1 | High when the regular group holds a single channel |
| conv1Busy | input | 1 | Converter 1 is sampling |
| conv2Busy | input | 1 | Converter 2 is sampling |
| conv1RegStart | output | 1 | Regular start strobe, converter 1 |
| conv2RegStart | output | 1 | Regular start strobe, converter 2 |
| conv1InjStart | output | 1 | Injected start strobe, converter 1 |
| conv2InjStart | output | 1 | Injected start strobe, converter 2 |
| conflictErr | output | 1 | Refused or withheld strobe pulse |
| overrunCount | output | 8 | Saturating count of dropped regular triggers |

## Verification
All sixteen mode codes are swept with an isolated regular trigger and then an isolated injected trigger, which separates the mode mapping and shows that the unused codes behave as independent. Directed sequences then measure the interleave gaps one cycle on either side of each strobe, run three injected triggers in a row to follow the alternation and its reset on a mode change, and change the mode in the middle of a slow sequence. Raising the busy inputs during a pending strobe, clearing singleChan, and holding the regular trigger high across many sequences cover the refusal, conflict and counter saturation paths.

// File: rtl/dual_seq_pkg.sv
package dual_seq_pkg;

  typedef enum logic [1:0] {REG_IND, REG_SIM, REG_FAST, REG_SLOW} regBehav_e;
  typedef enum logic [1:0] {INJ_IND, INJ_SIM, INJ_ALT} injBehav_e;

  typedef struct packed {
    logic c1Reg;
    logic c2Reg;
    logic c1Inj;
    logic c2Inj;
    logic err;
    logic overrun;
  } seqStrobe_t;

  function automatic regBehav_e regOf(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd6: regOf = REG_SIM;
      4'd3, 4'd7:       regOf = REG_FAST;
      4'd4, 4'd8:       regOf = REG_SLOW;
      default:          regOf = REG_IND;
    endcase
  endfunction

  function automatic injBehav_e injOf(input logic [3:0] code);
    case (code)
      4'd1, 4'd3, 4'd4, 4'd5: injOf = INJ_SIM;
      4'd2, 4'd9:             injOf = INJ_ALT;
      default:                injOf = INJ_IND;
    endcase
  endfunction

endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import dual_seq_pkg::*;
#(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] modeSel,
  input  logic       regTrig,
  input  logic       injTrig,
  input  logic       singleChan,
  input  logic       conv1Busy,
  input  logic       conv2Busy,
  output seqStrobe_t strb,
  output logic [3:0] activeMode,
  output logic       seqPending
);
  localparam int CNT_W = $clog2(2 * SLOW_GAP + 1);
  localparam logic [CNT_W-1:0] FAST_CNT  = CNT_W'(FAST_GAP);
  localparam logic [CNT_W-1:0] SLOW_CNT  = CNT_W'(SLOW_GAP);
  localparam logic [CNT_W-1:0] SLOW2_CNT = CNT_W'(2 * SLOW_GAP);

  logic [3:0]       modeQ;
  logic             pendQ;
  logic             slowQ;
  logic             altQ;
  logic [CNT_W-1:0] cntQ;

  regBehav_e regB;
  injBehav_e injB;
  logic regAccept, startSeq, fire2, fire1, seqDone;

  always_comb begin
    regB      = regOf(modeQ);
    injB      = injOf(modeQ);
    strb      = '0;
    regAccept = regTrig && !pendQ;
    strb.overrun = regTrig && pendQ;

    if (regAccept) begin
      case (regB)
        REG_SIM:  begin strb.c1Reg = 1'b1; strb.c2Reg = 1'b1; end
        REG_SLOW: begin
          if (singleChan) strb.c1Reg = 1'b1;
          else            strb.err   = 1'b1;
        end
        default:  strb.c1Reg = 1'b1;
      endcase
    end
    startSeq = regAccept && ((regB == REG_FAST) || (regB == REG_SLOW && singleChan));

    if (injTrig) begin
      case (injB)
        INJ_SIM: begin strb.c1Inj = 1'b1; strb.c2Inj = 1'b1; end
        INJ_ALT: begin
          if (altQ) strb.c2Inj = 1'b1;
          else      strb.c1Inj = 1'b1;
        end
        default: strb.c1Inj = 1'b1;
      endcase
    end

    fire2 = pendQ && (cntQ == (slowQ ? SLOW_CNT : FAST_CNT));
    fire1 = pendQ && slowQ && (cntQ == SLOW2_CNT);
    if (fire2) begin
      if (conv1Busy) strb.err   = 1'b1;
      else           strb.c2Reg = 1'b1;
    end
    if (fire1) begin
      if (conv2Busy) strb.err   = 1'b1;
      else           strb.c1Reg = 1'b1;
    end
    seqDone = fire1 || (fire2 && !slowQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
      pendQ <= 1'b0;
      slowQ <= 1'b0;
      altQ  <= 1'b0;
      cntQ  <= '0;
    end else begin
      if (!pendQ) modeQ <= modeSel;

      if (startSeq) begin
        pendQ <= 1'b1;
        slowQ <= (regB == REG_SLOW);
        cntQ  <= CNT_W'(1);
      end else if (seqDone) begin
        pendQ <= 1'b0;
        cntQ  <= '0;
      end else if (pendQ) begin
        cntQ  <= cntQ + 1'b1;
      end

      if (!pendQ && (modeSel != modeQ)) altQ <= 1'b0;
      else if (injTrig && injB == INJ_ALT) altQ <= ~altQ;
    end
  end

  assign activeMode = modeQ;
  assign seqPending = pendQ;
endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import dual_seq_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  output logic             conv1RegStart,
  output logic             conv2RegStart,
  output logic             conv1InjStart,
  output logic             conv2InjStart,
  output logic             conflictErr,
  output logic [OVR_W-1:0] overrunCount
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      conv1RegStart <= 1'b0;
      conv2RegStart <= 1'b0;
      conv1InjStart <= 1'b0;
      conv2InjStart <= 1'b0;
      conflictErr   <= 1'b0;
      overrunCount  <= '0;
    end else begin
      conv1RegStart <= strb.c1Reg;
      conv2RegStart <= strb.c2Reg;
      conv1InjStart <= strb.c1Inj;
      conv2InjStart <= strb.c2Inj;
      conflictErr   <= strb.err;
      if (strb.overrun && (overrunCount != '1)) overrunCount <= overrunCount + 1'b1;
    end
  end
endmodule

// File: rtl/dual_conv_trigger_seq.sv
module dual_conv_trigger_seq
  import dual_seq_pkg::*;
#(
  parameter int FAST_GAP = 7,
  parameter int SLOW_GAP = 14,
  parameter int OVR_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       modeSel,
  input  logic             regTrig,
  input  logic             injTrig,
  input  logic             singleChan,
  input  logic             conv1Busy,
  input  logic             conv2Busy,
  output logic             conv1RegStart,
  output logic             conv2RegStart,
  output logic             conv1InjStart,
  output logic             conv2InjStart,
  output logic             conflictErr,
  output logic [OVR_W-1:0] overrunCount
);
  seqStrobe_t strb;
  logic [3:0] activeMode;
  logic       seqPending;

  seq_ctrl #(.FAST_GAP(FAST_GAP), .SLOW_GAP(SLOW_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regTrig(regTrig), .injTrig(injTrig),
    .singleChan(singleChan), .conv1Busy(conv1Busy), .conv2Busy(conv2Busy),
    .strb(strb), .activeMode(activeMode), .seqPending(seqPending)
  );

  seq_dp #(.OVR_W(OVR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .conv1RegStart(conv1RegStart), .conv2RegStart(conv2RegStart),
    .conv1InjStart(conv1InjStart), .conv2InjStart(conv2InjStart),
    .conflictErr(conflictErr), .overrunCount(overrunCount)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk
  import dual_seq_pkg::*;
#(
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regTrig,
  input logic             singleChan,
  input logic             conv1RegStart,
  input logic             conv2RegStart,
  input logic             conv1InjStart,
  input logic             conv2InjStart,
  input logic             conflictErr,
  input logic [OVR_W-1:0] overrunCount,
  input logic [3:0]       activeMode,
  input logic             seqPending
);
  p_indep_conv1_only_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regOf($past(activeMode)) == REG_IND && injOf($past(activeMode)) == INJ_IND)
      |-> (!conv2RegStart && !conv2InjStart));

  p_alt_one_conv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (injOf($past(activeMode)) == INJ_ALT) |-> !(conv1InjStart && conv2InjStart));

  p_slow_refused_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regTrig && !seqPending && !singleChan && regOf(activeMode) == REG_SLOW)
      |=> (conflictErr && !conv1RegStart));

  p_ovr_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount == {OVR_W{1'b1}}) |=> (overrunCount == {OVR_W{1'b1}}));

  p_ovr_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCount == $past(overrunCount)) || (overrunCount == $past(overrunCount) + 1'b1));

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqPending |=> $stable(activeMode));
endmodule

bind dual_conv_trigger_seq seq_chk #(.OVR_W(OVR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regTrig(regTrig), .singleChan(singleChan),
  .conv1RegStart(conv1RegStart), .conv2RegStart(conv2RegStart),
  .conv1InjStart(conv1InjStart), .conv2InjStart(conv2InjStart),
  .conflictErr(conflictErr), .overrunCount(overrunCount),
  .activeMode(activeMode), .seqPending(seqPending)
);

// File: tb/sim_dual_conv_trigger_seq.sv
module sim_dual_conv_trigger_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modeSel = '0;
  logic       regTrig = 1'b0, injTrig = 1'b0, singleChan = 1'b1;
  logic       conv1Busy = 1'b0, conv2Busy = 1'b0;
  logic       conv1RegStart, conv2RegStart, conv1InjStart, conv2InjStart, conflictErr;
  logic [7:0] overrunCount;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #10 clk = ~clk;

  dual_conv_trigger_seq u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .regTrig(regTrig), .injTrig(injTrig),
    .singleChan(singleChan), .conv1Busy(conv1Busy), .conv2Busy(conv2Busy),
    .conv1RegStart(conv1RegStart), .conv2RegStart(conv2RegStart),
    .conv1InjStart(conv1InjStart), .conv2InjStart(conv2InjStart),
    .conflictErr(conflictErr), .overrunCount(overrunCount)
  );

  // {mode, regular strobes {c1,c2}, injected strobes {c1,c2}} one cycle after a trigger
  localparam logic [7:0] VEC [16] = '{
    8'h0_A, 8'h1_F, 8'h2_E, 8'h3_B, 8'h4_B, 8'h5_B, 8'h6_E, 8'h7_A,
    8'h8_A, 8'h9_A, 8'hA_A, 8'hB_A, 8'hC_A, 8'hD_A, 8'hE_A, 8'hF_A
  };

  function automatic logic [3:0] strobes();
    return {conv1RegStart, conv2RegStart, conv1InjStart, conv2InjStart};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input logic [3:0] m);
    modeSel = m;
    tick(2);
  endtask

  task automatic pulseReg();
    regTrig = 1'b1; tick(1); regTrig = 1'b0;
  endtask

  task automatic pulseInj();
    injTrig = 1'b1; tick(1); injTrig = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("reset strobes", {4'h0, strobes()}, 8'h00);
    chk("reset err/overrun", {conflictErr, overrunCount[6:0]}, 8'h00);

    // R1 R2 R3 R4 R6: mode sweep
    for (int i = 0; i < 16; i++) begin
      setMode(VEC[i][7:4]);
      pulseReg();
      chk($sformatf("R1 R2 R3 R4 reg mode %0d", i), {6'h0, strobes()[3:2]}, {6'h0, VEC[i][3:2]});
      tick(32);
      pulseInj();
      chk($sformatf("R1 R2 R6 inj mode %0d", i), {6'h0, strobes()[1:0]}, {6'h0, VEC[i][1:0]});
      tick(2);
    end

    // R3 fast gap
    setMode(4'd7);
    pulseReg();
    chk("R3 first strobe", {4'h0, strobes()}, 8'h08);
    tick(6);
    chk("R3 not at +6", {4'h0, strobes()}, 8'h00);
    tick(1);
    chk("R3 conv2 at +7", {4'h0, strobes()}, 8'h04);
    tick(3);

    // R7 withheld conv2 strobe
    pulseReg();
    conv1Busy = 1'b1;
    tick(7);
    chk("R7 withheld strobe", {4'h0, strobes()}, 8'h00);
    chk("R7 conflict pulse", {7'h0, conflictErr}, 8'h01);
    conv1Busy = 1'b0;
    tick(3);

    // R8 dropped trigger
    pulseReg();
    tick(1);
    pulseReg();
    chk("R8 dropped strobe", {4'h0, strobes()}, 8'h00);
    chk("R8 overrun count", overrunCount, 8'd1);
    tick(8);

    // R4 slow sequence
    setMode(4'd8);
    pulseReg();
    chk("R4 first conv1", {4'h0, strobes()}, 8'h08);
    tick(13);
    chk("R4 not at +13", {4'h0, strobes()}, 8'h00);
    tick(1);
    chk("R4 conv2 at +14", {4'h0, strobes()}, 8'h04);
    tick(14);
    chk("R4 conv1 at +28", {4'h0, strobes()}, 8'h08);
    tick(3);

    // R7 second conv1 withheld
    pulseReg();
    tick(27);
    conv2Busy = 1'b1;
    tick(1);
    chk("R7 slow withheld", {3'h0, conflictErr, strobes()}, 8'h10);
    conv2Busy = 1'b0;
    tick(3);

    // R5 refused
    singleChan = 1'b0;
    pulseReg();
    chk("R5 refused", {3'h0, conflictErr, strobes()}, 8'h10);
    tick(1);
    chk("R5 one-cycle pulse", {7'h0, conflictErr}, 8'h00);
    singleChan = 1'b1;
    tick(2);

    // R9 mode change during a pending slow sequence
    pulseReg();
    tick(5);
    modeSel = 4'd0;
    tick(23);
    chk("R9 sequence kept", {4'h0, strobes()}, 8'h08);
    tick(2);
    pulseReg();
    tick(7);
    chk("R9 new mode independent", {4'h0, strobes()}, 8'h00);
    tick(2);

    // R6 alternation and reset on mode change
    setMode(4'd9);
    pulseInj();
    chk("R6 alt 1", {4'h0, strobes()}, 8'h02);
    pulseInj();
    chk("R6 alt 2", {4'h0, strobes()}, 8'h01);
    pulseInj();
    chk("R6 alt 3", {4'h0, strobes()}, 8'h02);
    setMode(4'd2);
    pulseInj();
    chk("R9 alt reset", {4'h0, strobes()}, 8'h02);
    tick(2);

    // R8 saturation
    setMode(4'd8);
    regTrig = 1'b1;
    tick(400);
    regTrig = 1'b0;
    tick(32);
    chk("R8 saturated", overrunCount, 8'd255);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule